// File: doc/BRIEF.md
# Page Access Rights Evaluator

The block turns the protection information of one page, together with a privilege key and segment attributes, into a set of read, write and execute rights. It then decides whether a single access of a given kind may proceed. It takes the low and high bits of the second word of a translation entry directly and works out the protection code and the execute-inhibit bits from them. A mode input selects whether that word is in the short (32-bit) or long (64-bit) entry layout.

One request is presented per cycle, qualified by a valid strobe. The result appears on registered outputs exactly one cycle later, with its own valid strobe. Table walking and address formation happen elsewhere. This unit only answers the question "what may this page do, and is this access allowed".

Top module: `page_rights_eval`

## Requirements
- R1: With key 0, protection codes 0, 1 and 2 yield read and write, and codes 3 and 6 yield read only. Rights are reported as a 3-bit vector: bit 2 = read, bit 1 = write, bit 0 = execute.
- R2: With key 1, codes 0 and 6 yield neither read nor write, codes 1 and 3 yield read only, and code 2 yields read and write.
- R3: For either key, any code not listed in R1 or R2 (4, 5 and 7) yields neither read nor write.
- R4: In short mode (`long_fmt`=0), the protection code is `{0, entry_word[1:0]}`. In long mode (`long_fmt`=1), it is `{entry_word[63], entry_word[1:0]}`.
- R5: Execute is granted only when the combined no-execute indicator is 0. In short mode that indicator is `seg_noexec` alone, and `entry_word[3:2]` is ignored. In long mode it is the OR of `seg_noexec`, `entry_word[2]` (no-execute) and `entry_word[3]` (guarded).
- R6: The access kind is encoded as 2'b00 load, 2'b01 store and 2'b10 fetch. A load needs read, a store needs write and a fetch needs execute. Code 2'b11 has the fetch bit set and is treated as a fetch, so the fetch takes priority over the store bit.
- R7: `grant` is 1 exactly when the access is allowed. `fault_code` is 2'b00 on a grant and 2'b10 (protection violation) on a denial. The value 2'b01 is kept for "no match" and is never produced here.
- R8: `out_valid` equals `in_valid` delayed by one clock. While `in_valid` is low, `rights`, `grant` and `fault_code` hold their last values.
- R9: While reset is asserted, `out_valid`, `rights`, `grant` and `fault_code` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request qualifier |
| key | input | 1 | Privilege key selecting the rights table |
| long_fmt | input | 1 | 1 = 64-bit entry layout, 0 = 32-bit layout |
| entry_word | input | 64 | Second word of the translation entry |
| seg_noexec | input | 1 | Segment no-execute attribute |
| acc_kind | input | 2 | 00 load, 01 store, 10 fetch (11 = fetch) |
| out_valid | output | 1 | Result qualifier, one cycle after in_valid |
| rights | output | 3 | {read, write, execute} |
| grant | output | 1 | Access allowed |
| fault_code | output | 2 | 00 granted, 10 protection violation |

## Verification
Several behaviours are checked by assertions on every cycle:
- the one-cycle valid delay;
- the holding of results while idle;
- the removal of execute by any no-execute source;
- the folding of code 7 to no read or write access;
- the agreement between grant and fault code;
- a fetch being granted exactly when execute is present.

The full rights tables for both keys, the extraction of the code from each entry layout, and the priority of fetch over store are shown only by the bench's exhaustive sweep. That sweep covers every key, code-bearing bit, no-execute source, mode and access kind, compared against an independent model.

// File: rtl/page_rights_pkg.sv
package page_rights_pkg;
  localparam int RIGHTS_W = 3;
  localparam int PCODE_W  = 3;
  localparam int FAULT_W  = 2;

  typedef logic [RIGHTS_W-1:0] rights_t;   // {R, W, X}
  typedef logic [PCODE_W-1:0]  pcode_t;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10
  } acc_kind_e;

  typedef enum logic [FAULT_W-1:0] {
    FLT_NONE    = 2'b00,
    FLT_NOMATCH = 2'b01,
    FLT_PROT    = 2'b10
  } fault_e;

  localparam int RB_R = 2;
  localparam int RB_W = 1;
  localparam int RB_X = 0;
endpackage

// File: rtl/page_code_fmt.sv
module page_code_fmt
  import page_rights_pkg::*;
#(
  parameter int ENTRY_W  = 64,
  parameter int NX_BIT   = 2,
  parameter int GRD_BIT  = 3
) (
  input  logic               long_fmt,
  input  logic [ENTRY_W-1:0] entry_word,
  input  logic               seg_noexec,
  output pcode_t             pcode,
  output logic               noexec
);
  localparam int HI_BIT = ENTRY_W - 1;

  logic long_hi;
  logic long_nx;

  always_comb begin
    long_hi = long_fmt & entry_word[HI_BIT];
    long_nx = long_fmt & (entry_word[NX_BIT] | entry_word[GRD_BIT]);
    pcode   = {long_hi, entry_word[1:0]};
    noexec  = seg_noexec | long_nx;
  end
endmodule

// File: rtl/page_rights_tbl.sv
module page_rights_tbl
  import page_rights_pkg::*;
(
  input  logic   key,
  input  pcode_t pcode,
  input  logic   noexec,
  output rights_t rights
);
  logic rd;
  logic wr;

  always_comb begin
    rd = 1'b0;
    wr = 1'b0;
    if (!key) begin
      unique case (pcode)
        3'd0, 3'd1, 3'd2: begin rd = 1'b1; wr = 1'b1; end
        3'd3, 3'd6:       rd = 1'b1;
        default:          ;
      endcase
    end else begin
      unique case (pcode)
        3'd1, 3'd3: rd = 1'b1;
        3'd2:       begin rd = 1'b1; wr = 1'b1; end
        default:    ;
      endcase
    end
    rights       = '0;
    rights[RB_R] = rd;
    rights[RB_W] = wr;
    rights[RB_X] = ~noexec;
  end
endmodule

// File: rtl/page_access_chk.sv
module page_access_chk
  import page_rights_pkg::*;
(
  input  rights_t    rights,
  input  logic [1:0] acc_kind,
  output logic       allow,
  output logic [FAULT_W-1:0] fault
);
  always_comb begin
    if (acc_kind[1])        allow = rights[RB_X];
    else if (acc_kind[0])   allow = rights[RB_W];
    else                    allow = rights[RB_R];
    fault = allow ? FLT_NONE : FLT_PROT;
  end
endmodule

// File: rtl/page_rights_eval.sv
module page_rights_eval
  import page_rights_pkg::*;
#(
  parameter int ENTRY_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               key,
  input  logic               long_fmt,
  input  logic [ENTRY_W-1:0] entry_word,
  input  logic               seg_noexec,
  input  logic [1:0]         acc_kind,
  output logic               out_valid,
  output logic [RIGHTS_W-1:0] rights,
  output logic               grant,
  output logic [FAULT_W-1:0] fault_code
);
  localparam int HI_BIT = ENTRY_W - 1;

  pcode_t  pcode_c;
  logic    noexec_c;
  rights_t rights_c;
  logic    allow_c;
  logic [FAULT_W-1:0] fault_c;

  page_code_fmt #(.ENTRY_W(ENTRY_W)) u_fmt (
    .long_fmt   (long_fmt),
    .entry_word (entry_word),
    .seg_noexec (seg_noexec),
    .pcode      (pcode_c),
    .noexec     (noexec_c)
  );

  page_rights_tbl u_tbl (
    .key    (key),
    .pcode  (pcode_c),
    .noexec (noexec_c),
    .rights (rights_c)
  );

  page_access_chk u_chk (
    .rights   (rights_c),
    .acc_kind (acc_kind),
    .allow    (allow_c),
    .fault    (fault_c)
  );

  // next-state
  logic               vld_d;
  rights_t            rights_d;
  logic               grant_d;
  logic [FAULT_W-1:0] fault_d;

  always_comb begin
    vld_d    = in_valid;
    rights_d = rights;
    grant_d  = grant;
    fault_d  = fault_code;
    if (in_valid) begin
      rights_d = rights_c;
      grant_d  = allow_c;
      fault_d  = fault_c;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      rights     <= '0;
      grant      <= 1'b0;
      fault_code <= '0;
    end else begin
      out_valid  <= vld_d;
      rights     <= rights_d;
      grant      <= grant_d;
      fault_code <= fault_d;
    end
  end

  // checks
  p_valid_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));
  p_valid_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(rights) && $stable(grant) && $stable(fault_code)));
  p_seg_nx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && seg_noexec) |=> !rights[RB_X]);
  p_entry_nx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && long_fmt && (entry_word[2] || entry_word[3])) |=> !rights[RB_X]);
  p_code7_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && long_fmt && entry_word[HI_BIT] && (entry_word[1:0] == 2'b11))
      |=> (!rights[RB_R] && !rights[RB_W]));
  p_fault_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (grant ? (fault_code == 2'b00) : (fault_code == 2'b10)));
  p_fetch_x_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && acc_kind[1]) |=> (grant == rights[RB_X]));
endmodule

// File: tb/page_rights_eval_tb.sv
module page_rights_eval_tb;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        key;
  logic        long_fmt;
  logic [63:0] entry_word;
  logic        seg_noexec;
  logic [1:0]  acc_kind;
  logic        out_valid;
  logic [2:0]  rights;
  logic        grant;
  logic [1:0]  fault_code;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  logic [5:0] expq [$];   // {rights, grant, fault}
  logic [5:0] last_exp;

  page_rights_eval u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .key(key),
    .long_fmt(long_fmt), .entry_word(entry_word), .seg_noexec(seg_noexec),
    .acc_kind(acc_kind), .out_valid(out_valid), .rights(rights),
    .grant(grant), .fault_code(fault_code)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Independent model from the requirements
  function automatic logic [5:0] model(input logic k, input logic lf,
      input logic [63:0] w, input logic snx, input logic [1:0] kind);
    logic [2:0] code;
    logic rd, wr, x, ok;
    code = lf ? {w[63], w[1:0]} : {1'b0, w[1:0]};           // R4
    rd = 0; wr = 0;
    if (k == 0) begin                                        // R1
      if (code <= 2) begin rd = 1; wr = 1; end
      else if (code == 3 || code == 6) rd = 1;
    end else begin                                           // R2
      if (code == 2) begin rd = 1; wr = 1; end
      else if (code == 1 || code == 3) rd = 1;
    end                                                      // R3 otherwise none
    x = !(snx || (lf && (w[2] || w[3])));                    // R5
    if (kind[1]) ok = x; else if (kind[0]) ok = wr; else ok = rd;  // R6
    return {rd, wr, x, ok, ok ? 2'b00 : 2'b10};              // R7
  endfunction

  task automatic drive(input logic k, input logic lf, input logic [63:0] w,
      input logic snx, input logic [1:0] kind);
    @(negedge clk);
    in_valid = 1; key = k; long_fmt = lf; entry_word = w;
    seg_noexec = snx; acc_kind = kind;
    last_exp = model(k, lf, w, snx, kind);
    expq.push_back(last_exp);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (expq.size() == 0) begin
        chk(0, "R8 unexpected out_valid", 1, 0);
      end else begin
        logic [5:0] e;
        e = expq.pop_front();
        chk(rights == e[5:3], "R1 R2 R3 R4 R5 rights", rights, e[5:3]);
        chk(grant == e[2], "R6 grant", grant, e[2]);
        chk(fault_code == e[1:0], "R7 fault_code", fault_code, e[1:0]);
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(0, "watchdog", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; in_valid = 0; key = 0; long_fmt = 0; entry_word = '0;
    seg_noexec = 0; acc_kind = 0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(out_valid == 0 && rights == 0 && grant == 0 && fault_code == 0,
        "R9 reset outputs", {out_valid, rights, grant, fault_code}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0, "R9 idle after reset", out_valid, 0);

    for (int lf = 0; lf < 2; lf++)
      for (int k = 0; k < 2; k++)
        for (int hi = 0; hi < 2; hi++)
          for (int lo = 0; lo < 4; lo++)
            for (int nxg = 0; nxg < 4; nxg++)
              for (int s = 0; s < 2; s++)
                for (int kd = 0; kd < 4; kd++) begin
                  logic [63:0] w;
                  w = {32'h5A5A_0000, 32'h1230_0000};   // unrelated bits set
                  w[63] = hi[0];
                  w[1:0] = lo[1:0];
                  w[3:2] = nxg[1:0];
                  drive(k[0], lf[0], w, s[0], kd[1:0]);
                end

    // R8: idle cycles keep the last result and drop out_valid
    @(negedge clk);
    in_valid = 0; key = ~key; entry_word = ~entry_word; acc_kind = 2'b00;
    repeat (3) begin
      @(negedge clk);
      chk(out_valid == 0, "R8 out_valid low when idle", out_valid, 0);
      chk({rights, grant, fault_code} == last_exp, "R8 hold while idle",
          {rights, grant, fault_code}, last_exp);
    end
    chk(expq.size() == 0, "R8 all results delivered", expq.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule